// File: doc/BRIEF.md
# Video Processor Command Port Decoder

This block sits behind the two host-facing ports of a tile-based video processor. Writes to the control port come in two kinds. Some program one entry of a 24-entry register file. Others select a memory access: a first half is held until the second half arrives. The register file also feeds a set of decoded fields: plane base addresses, scroll-plane dimensions, the auto-increment step, and the DMA length, source and transfer kind.

Once an access command is complete, the block owns a destination address and a target memory, which is one of video RAM, colour RAM or vertical-scroll RAM. Each data-port read or write becomes a one-cycle strobe to that memory at the wrapped address, and the address then advances by the auto-increment step. Some command codes request a DMA, and the block raises a one-cycle start pulse for each one. A fill request is armed by the command and started by the next data-port write, which supplies the fill word. The data movement of a DMA and all rendering belong to other blocks.

Top module: `vdp_cmd_port`

## Requirements
- R1: A 16-bit control write with bits 15:14 equal to 2'b10 and no half pending is a register write: register index in bits 12:8, value in bits 7:0. An index of 24 or above changes nothing. reg_val shows the register chosen by reg_sel, and 0 for an undefined index.
- R2: Plane bases are derived by shifting: scroll-A base = reg2<<10, window base = reg3<<10, horizontal-scroll base = reg13<<10, scroll-B base = reg4<<13, sprite base = reg5<<9, each truncated to 16 bits. Auto-increment is reg15.
- R3: Register 16 holds the scroll size: width code in bits 1:0 and height code in bits 5:4. Code 0 means 32 cells, 1 means 64, 3 means 128, and 2 means 32.
- R4: The DMA length is {reg20, reg19}. The DMA source is reg23<<17 | reg22<<9 | reg21<<1. reg23 is masked to 7 bits when its bit 7 is clear and to 6 bits when it is set. dma_xfer is reg23 bits 7:6.
- R5: A 16-bit control write that is not a register write, made with no half pending, is latched as the first half. The next control write always completes the command, even if it looks like a register write, and clears the pending half. Reset clears the pending half.
- R6: A 32-bit control write (ctrl_wide) supplies the first half in ctrl_data[31:16] and the second half in [15:0], and completes the command in one cycle.
- R7: The access code is {second[7:4], first[15:14]}. The destination is {second[1:0], first[13:0]}.
- R8: With code&0x0E equal to 0 the target is VRAM (mem_sel 0). Equal to 4 selects VSRAM (mem_sel 2). Any other value selects CRAM (mem_sel 1). mem_addr is the destination modulo 65536, 128 or 80 bytes for VRAM, CRAM or VSRAM.
- R9: A data write drives mem_wr, and a data read drives mem_rd, in the same cycle at the current mem_addr. Either access then adds the auto-increment to the destination.
- R10: A completed command with code bit 5 set pulses dma_start for one cycle after the completing write. The kind is COPY (2) if code bit 4 is set. Otherwise it is MEM (1), unless dma_xfer is 2'b10.
- R11: If code bit 5 is set, bit 4 is clear and dma_xfer is 2'b10, a fill is armed. The next data write then drives no mem_wr and leaves the address alone. It stores the fill word, pulses dma_start with kind FILL (3), and disarms the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control port write strobe |
| ctrl_wide | input | 1 | Control write carries both halves |
| ctrl_data | input | 32 | Control write data (16-bit writes use bits 15:0) |
| data_wr | input | 1 | Data port write strobe |
| data_rd | input | 1 | Data port read strobe |
| data_wdata | input | 16 | Data port write word |
| reg_sel | input | 5 | Register index to view |
| reg_val | output | 8 | Value of the viewed register |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_sel | output | 2 | Target memory: 0 VRAM, 1 CRAM, 2 VSRAM |
| mem_addr | output | 16 | Wrapped byte address in the target |
| mem_wdata | output | 16 | Memory write word |
| base_a | output | 16 | Scroll-A plane base |
| base_win | output | 16 | Window plane base |
| base_b | output | 16 | Scroll-B plane base |
| base_spr | output | 16 | Sprite table base |
| base_hs | output | 16 | Horizontal-scroll table base |
| auto_inc | output | 8 | Address step per data access |
| scroll_w | output | 8 | Scroll plane width in cells |
| scroll_h | output | 8 | Scroll plane height in cells |
| dma_len | output | 16 | DMA length |
| dma_src | output | 24 | DMA source address |
| dma_xfer | output | 2 | DMA transfer kind bits |
| dma_start | output | 1 | One-cycle DMA start pulse |
| dma_kind | output | 2 | Kind of the last start: 1 MEM, 2 COPY, 3 FILL |
| fill_word | output | 16 | Fill value captured by the fill-starting write |

## Verification
The assertions watch several things on every cycle. They check the pending half being set after a lone first half and cleared by a wide write or by reset. They check that every data access advances the destination by exactly the auto-increment step, and that CRAM and VSRAM addresses stay below their sizes. They check that a start pulse only follows a port write, and that an armed fill turns the next data write into a fill start. The exact field decoding cannot be shown by the assertions: the shifts and the source-address masking, the assembly of code and address from scattered bits, and which target and DMA kind each code picks. Nor can they show that undefined indices are ignored, or that a register-form word completes a pending command. Only the bench's scenarios with known expected values can show these.

// File: rtl/vdp_cmd_pkg.sv
// Shared encodings for the command port decoder: target memories, DMA
// kinds and the register indices whose position the host software relies on.
package vdp_cmd_pkg;
    typedef enum logic [1:0] {
        TGT_VRAM  = 2'd0,
        TGT_CRAM  = 2'd1,
        TGT_VSRAM = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        DMA_NONE = 2'd0,
        DMA_MEM  = 2'd1,
        DMA_COPY = 2'd2,
        DMA_FILL = 2'd3
    } dma_e;

    localparam int IX_BASE_A   = 2;
    localparam int IX_BASE_WIN = 3;
    localparam int IX_BASE_B   = 4;
    localparam int IX_BASE_SPR = 5;
    localparam int IX_BASE_HS  = 13;
    localparam int IX_STEP     = 15;
    localparam int IX_PLANE_SZ = 16;
    localparam int IX_LEN_LO   = 19;
    localparam int IX_LEN_HI   = 20;
    localparam int IX_SRC_LO   = 21;
    localparam int IX_SRC_MID  = 22;
    localparam int IX_SRC_HI   = 23;
endpackage

// File: rtl/vdp_cmd_assemble.sv
// Control port front end. It classifies each control write as a register
// write or a command half. It holds a lone first half until the second one
// arrives and presents the finished command for one cycle.
// Assumes: at most one control write per cycle; wide writes carry the first
// half in bits 31:16.
module vdp_cmd_assemble (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        ctrl_wide,
    input  logic [31:0] ctrl_data,
    output logic        reg_wr,
    output logic [4:0]  reg_idx,
    output logic [7:0]  reg_byte,
    output logic        cmd_done,
    output logic [5:0]  cmd_code,
    output logic [15:0] cmd_addr,
    output logic        pending
);
    logic        pend_q;
    logic [15:0] held_q;
    logic [15:0] first_w;
    logic [15:0] second_w;

    // Classify the write and pick the two command halves.
    always_comb begin
        reg_wr   = ctrl_wr && !ctrl_wide && !pend_q && (ctrl_data[15:14] == 2'b10);
        cmd_done = ctrl_wr && (ctrl_wide || pend_q);
        first_w  = ctrl_wide ? ctrl_data[31:16] : held_q;
        second_w = ctrl_data[15:0];
        reg_idx  = ctrl_data[12:8];
        reg_byte = ctrl_data[7:0];
        cmd_code = {second_w[7:4], first_w[15:14]};
        cmd_addr = {second_w[1:0], first_w[13:0]};
    end

    // Pending-half latch: set by a lone first half, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            held_q <= '0;
        end else if (ctrl_wr && !reg_wr) begin
            if (cmd_done) begin
                pend_q <= 1'b0;
            end else begin
                pend_q <= 1'b1;
                held_q <= ctrl_data[15:0];
            end
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/vdp_cmd_regs.sv
// Register file plus the fields decoded from it: plane bases, scroll size,
// step, DMA length, source and transfer kind.
// Assumes: index values at or above REG_COUNT are silently dropped.
module vdp_cmd_regs
    import vdp_cmd_pkg::*;
#(
    parameter int REG_COUNT = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [4:0]  idx,
    input  logic [7:0]  wbyte,
    input  logic [4:0]  view_sel,
    output logic [7:0]  view_val,
    output logic [15:0] base_a,
    output logic [15:0] base_win,
    output logic [15:0] base_b,
    output logic [15:0] base_spr,
    output logic [15:0] base_hs,
    output logic [7:0]  step,
    output logic [7:0]  plane_w,
    output logic [7:0]  plane_h,
    output logic [15:0] dma_len,
    output logic [23:0] dma_src,
    output logic [1:0]  dma_xfer
);
    logic [7:0] regs_q [REG_COUNT];
    logic [6:0] src_top;

    // Map a two-bit plane size code to a cell count.
    function automatic logic [7:0] cells(input logic [1:0] code);
        case (code)
            2'd1:    cells = 8'd64;
            2'd3:    cells = 8'd128;
            default: cells = 8'd32;
        endcase
    endfunction

    // Register file storage; writes to undefined indices are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
        end else if (wr && ({27'b0, idx} < REG_COUNT)) begin
            regs_q[idx] <= wbyte;
        end
    end

    // Decode the fields the rest of the chip consumes.
    always_comb begin
        view_val = ({27'b0, view_sel} < REG_COUNT) ? regs_q[view_sel] : 8'h00;
        base_a   = {regs_q[IX_BASE_A][5:0],   10'b0};
        base_win = {regs_q[IX_BASE_WIN][5:0], 10'b0};
        base_hs  = {regs_q[IX_BASE_HS][5:0],  10'b0};
        base_b   = {regs_q[IX_BASE_B][2:0],   13'b0};
        base_spr = {regs_q[IX_BASE_SPR][6:0], 9'b0};
        step     = regs_q[IX_STEP];
        plane_w  = cells(regs_q[IX_PLANE_SZ][1:0]);
        plane_h  = cells(regs_q[IX_PLANE_SZ][5:4]);
        dma_len  = {regs_q[IX_LEN_HI], regs_q[IX_LEN_LO]};
        src_top  = regs_q[IX_SRC_HI][7] ? {1'b0, regs_q[IX_SRC_HI][5:0]}
                                         : regs_q[IX_SRC_HI][6:0];
        dma_src  = {src_top, regs_q[IX_SRC_MID], regs_q[IX_SRC_LO], 1'b0};
        dma_xfer = regs_q[IX_SRC_HI][7:6];
    end
endmodule

// File: rtl/vdp_cmd_access.sv
// Access engine. It holds the destination address and target chosen by the
// last command, turns data port traffic into memory strobes at a wrapped
// address, and issues DMA start pulses, including the deferred fill.
// Assumes: a data access and a command completion never share a cycle.
module vdp_cmd_access
    import vdp_cmd_pkg::*;
#(
    parameter int VRAM_BYTES  = 65536,
    parameter int CRAM_BYTES  = 128,
    parameter int VSRAM_BYTES = 80,
    localparam int ADDR_W     = $clog2(VRAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic [5:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [15:0]       data_wdata,
    input  logic [7:0]        step,
    input  logic [1:0]        dma_xfer,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [1:0]        mem_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              dma_start,
    output logic [1:0]        dma_kind,
    output logic [15:0]       fill_word,
    output logic [ADDR_W-1:0] dest,
    output logic              armed
);
    logic [ADDR_W-1:0] dest_q;
    tgt_e              sel_q;
    tgt_e              tgt_new;
    logic              armed_q;
    logic              start_q;
    dma_e              kind_q;
    logic [15:0]       fill_q;

    // Choose the target memory from the code bits that name it.
    always_comb begin
        case (cmd_code & 6'h0E)
            6'h00:   tgt_new = TGT_VRAM;
            6'h04:   tgt_new = TGT_VSRAM;
            default: tgt_new = TGT_CRAM;
        endcase
    end

    // Destination, target, fill arming and DMA start sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q  <= '0;
            sel_q   <= TGT_VRAM;
            armed_q <= 1'b0;
            start_q <= 1'b0;
            kind_q  <= DMA_NONE;
            fill_q  <= '0;
        end else begin
            start_q <= 1'b0;
            if (cmd_done) begin
                dest_q  <= cmd_addr;
                sel_q   <= tgt_new;
                armed_q <= 1'b0;
                if (cmd_code[5]) begin
                    if (cmd_code[4]) begin
                        start_q <= 1'b1;
                        kind_q  <= DMA_COPY;
                    end else if (dma_xfer == 2'b10) begin
                        armed_q <= 1'b1;
                    end else begin
                        start_q <= 1'b1;
                        kind_q  <= DMA_MEM;
                    end
                end
            end else if (data_wr && armed_q) begin
                fill_q  <= data_wdata;
                start_q <= 1'b1;
                kind_q  <= DMA_FILL;
                armed_q <= 1'b0;
            end else if (data_wr || data_rd) begin
                dest_q <= dest_q + ADDR_W'(step);
            end
        end
    end

    // Memory strobes and the address wrapped to the selected memory size.
    always_comb begin
        mem_wr = data_wr && !armed_q;
        mem_rd = data_rd;
        case (sel_q)
            TGT_CRAM:  mem_addr = ADDR_W'(32'(dest_q) % CRAM_BYTES);
            TGT_VSRAM: mem_addr = ADDR_W'(32'(dest_q) % VSRAM_BYTES);
            default:   mem_addr = ADDR_W'(32'(dest_q) % VRAM_BYTES);
        endcase
    end

    assign mem_sel   = sel_q;
    assign dma_start = start_q;
    assign dma_kind  = kind_q;
    assign fill_word = fill_q;
    assign dest      = dest_q;
    assign armed     = armed_q;
endmodule

// File: rtl/vdp_cmd_port.sv
// Command port decoder top. It joins the control-port front end, the
// register file and the access engine. The memories and the DMA mover are
// outside; this block only issues strobes, addresses and start pulses.
// Assumes: the host does not write the control and data ports in one cycle.
module vdp_cmd_port
    import vdp_cmd_pkg::*;
#(
    parameter int REG_COUNT   = 24,
    parameter int VRAM_BYTES  = 65536,
    parameter int CRAM_BYTES  = 128,
    parameter int VSRAM_BYTES = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        ctrl_wide,
    input  logic [31:0] ctrl_data,
    input  logic        data_wr,
    input  logic        data_rd,
    input  logic [15:0] data_wdata,
    input  logic [4:0]  reg_sel,
    output logic [7:0]  reg_val,
    output logic        mem_wr,
    output logic        mem_rd,
    output logic [1:0]  mem_sel,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic [15:0] base_a,
    output logic [15:0] base_win,
    output logic [15:0] base_b,
    output logic [15:0] base_spr,
    output logic [15:0] base_hs,
    output logic [7:0]  auto_inc,
    output logic [7:0]  scroll_w,
    output logic [7:0]  scroll_h,
    output logic [15:0] dma_len,
    output logic [23:0] dma_src,
    output logic [1:0]  dma_xfer,
    output logic        dma_start,
    output logic [1:0]  dma_kind,
    output logic [15:0] fill_word
);
    logic        reg_wr;
    logic [4:0]  reg_idx;
    logic [7:0]  reg_byte;
    logic        cmd_done;
    logic [5:0]  cmd_code;
    logic [15:0] cmd_addr;
    logic        pend;
    logic [15:0] dest;
    logic        armed;

    vdp_cmd_assemble u_asm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wide(ctrl_wide), .ctrl_data(ctrl_data),
        .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_byte(reg_byte),
        .cmd_done(cmd_done), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .pending(pend)
    );

    vdp_cmd_regs #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .idx(reg_idx), .wbyte(reg_byte),
        .view_sel(reg_sel), .view_val(reg_val),
        .base_a(base_a), .base_win(base_win), .base_b(base_b),
        .base_spr(base_spr), .base_hs(base_hs), .step(auto_inc),
        .plane_w(scroll_w), .plane_h(scroll_h),
        .dma_len(dma_len), .dma_src(dma_src), .dma_xfer(dma_xfer)
    );

    vdp_cmd_access #(
        .VRAM_BYTES(VRAM_BYTES), .CRAM_BYTES(CRAM_BYTES), .VSRAM_BYTES(VSRAM_BYTES)
    ) u_acc (
        .clk(clk), .rst_n(rst_n),
        .cmd_done(cmd_done), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .data_wr(data_wr), .data_rd(data_rd), .data_wdata(data_wdata),
        .step(auto_inc), .dma_xfer(dma_xfer),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .dma_start(dma_start), .dma_kind(dma_kind), .fill_word(fill_word),
        .dest(dest), .armed(armed)
    );

    assign mem_wdata = data_wdata;
endmodule

// File: rtl/vdp_cmd_port_chk.sv
// Temporal checks for the command port decoder, bound to its top module.
// Assumes: it observes only ports and the signals joining the submodules.
module vdp_cmd_port_chk #(
    parameter int CRAM_BYTES  = 128,
    parameter int VSRAM_BYTES = 80
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr,
    input logic        ctrl_wide,
    input logic [31:0] ctrl_data,
    input logic        data_wr,
    input logic        data_rd,
    input logic [1:0]  mem_sel,
    input logic [15:0] mem_addr,
    input logic        dma_start,
    input logic [1:0]  dma_kind,
    input logic        pend,
    input logic [15:0] dest,
    input logic [7:0]  auto_inc,
    input logic        armed
);
    // A lone first half leaves a pending half behind.
    assert_half_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !ctrl_wide && !pend && (ctrl_data[15:14] != 2'b10) |=> pend);

    // Reset always empties the pending latch.
    assert_reset_clears_R5: assert property (@(posedge clk)
        !rst_n |=> !pend);

    // A wide write finishes the command at once.
    assert_wide_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_wide |=> !pend);

    // Every normal data access advances by the step.
    assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd || (data_wr && !armed)) && !ctrl_wr
        |=> dest == 16'($past(dest) + {8'b0, $past(auto_inc)}));

    // Small memories never see an address past their end.
    assert_cram_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel == 2'd1 |-> 32'(mem_addr) < CRAM_BYTES);
    assert_vsram_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel == 2'd2 |-> 32'(mem_addr) < VSRAM_BYTES);

    // A start pulse is always caused by a port write.
    assert_start_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(ctrl_wr || data_wr));

    // An armed fill turns the next data write into a fill start.
    assert_fill_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && armed && !ctrl_wr |=> dma_start && (dma_kind == 2'd3) && !armed);
endmodule

bind vdp_cmd_port vdp_cmd_port_chk #(
    .CRAM_BYTES(CRAM_BYTES), .VSRAM_BYTES(VSRAM_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wide(ctrl_wide),
    .ctrl_data(ctrl_data), .data_wr(data_wr), .data_rd(data_rd),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .dma_start(dma_start),
    .dma_kind(dma_kind), .pend(pend), .dest(dest), .auto_inc(auto_inc),
    .armed(armed)
);

// File: tb/sim_vdp_cmd_port.sv
module sim_vdp_cmd_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic        ctrl_wide = 1'b0;
    logic [31:0] ctrl_data = '0;
    logic        data_wr = 1'b0;
    logic        data_rd = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [4:0]  reg_sel = '0;
    logic [7:0]  reg_val;
    logic        mem_wr, mem_rd;
    logic [1:0]  mem_sel;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] base_a, base_win, base_b, base_spr, base_hs;
    logic [7:0]  auto_inc, scroll_w, scroll_h;
    logic [15:0] dma_len;
    logic [23:0] dma_src;
    logic [1:0]  dma_xfer;
    logic        dma_start;
    logic [1:0]  dma_kind;
    logic [15:0] fill_word;

    int checks = 0;
    int fails  = 0;

    vdp_cmd_port u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wide(ctrl_wide),
        .ctrl_data(ctrl_data), .data_wr(data_wr), .data_rd(data_rd),
        .data_wdata(data_wdata), .reg_sel(reg_sel), .reg_val(reg_val),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .base_a(base_a), .base_win(base_win),
        .base_b(base_b), .base_spr(base_spr), .base_hs(base_hs),
        .auto_inc(auto_inc), .scroll_w(scroll_w), .scroll_h(scroll_h),
        .dma_len(dma_len), .dma_src(dma_src), .dma_xfer(dma_xfer),
        .dma_start(dma_start), .dma_kind(dma_kind), .fill_word(fill_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register-write vectors: {word, field id, expected value}.
    // Fields: 0 scrollA 1 window 2 scrollB 3 sprite 4 hscroll 5 step
    // 6 width 7 height 8 length 9 source 10 kind bits 11 viewed register.
    localparam int NV = 18;
    localparam logic [43:0] VEC [NV] = '{
        {16'h8202, 4'd0,  24'h000800},
        {16'h8305, 4'd1,  24'h001400},
        {16'h8403, 4'd2,  24'h006000},
        {16'h857F, 4'd3,  24'h00FE00},
        {16'h8D3F, 4'd4,  24'h00FC00},
        {16'h8F02, 4'd5,  24'h000002},
        {16'h9031, 4'd6,  24'h000040},
        {16'h9031, 4'd7,  24'h000080},
        {16'h9002, 4'd6,  24'h000020},
        {16'h93CD, 4'd8,  24'h0000CD},
        {16'h94AB, 4'd8,  24'h00ABCD},
        {16'h9534, 4'd9,  24'h000068},
        {16'h9612, 4'd9,  24'h002468},
        {16'h9745, 4'd9,  24'h8A2468},
        {16'h97C5, 4'd9,  24'h0A2468},
        {16'h97C5, 4'd10, 24'h000003},
        {16'h9785, 4'd9,  24'h0A2468},
        {16'h8C81, 4'd11, 24'h000081}
    };

    function automatic logic [31:0] field(input logic [3:0] f);
        case (f)
            4'd0:  field = 32'(base_a);
            4'd1:  field = 32'(base_win);
            4'd2:  field = 32'(base_b);
            4'd3:  field = 32'(base_spr);
            4'd4:  field = 32'(base_hs);
            4'd5:  field = 32'(auto_inc);
            4'd6:  field = 32'(scroll_w);
            4'd7:  field = 32'(scroll_h);
            4'd8:  field = 32'(dma_len);
            4'd9:  field = 32'(dma_src);
            4'd10: field = 32'(dma_xfer);
            default: field = 32'(reg_val);
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ctrl16(input logic [15:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wide = 1'b0; ctrl_data = {16'h0, w};
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic ctrl32(input logic [31:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wide = 1'b1; ctrl_data = w;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_wide = 1'b0;
    endtask

    // Data access: captures strobe, address and target inside the cycle.
    task automatic daccess(input logic rd, input logic [15:0] w,
                           output logic strobe, output logic [15:0] a,
                           output logic [1:0] s);
        @(negedge clk);
        data_rd = rd; data_wr = !rd; data_wdata = w;
        #1;
        strobe = rd ? mem_rd : mem_wr;
        a = mem_addr; s = mem_sel;
        @(negedge clk);
        data_rd = 1'b0; data_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic        st;
        logic [15:0] a;
        logic [1:0]  s;
        logic [23:0] src_keep;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R2", "reset scrollA base", 32'(base_a), 32'h0);
        check("R3", "reset width", 32'(scroll_w), 32'd32);
        check("R4", "reset length", 32'(dma_len), 32'h0);
        check("R10", "reset start", 32'(dma_start), 32'h0);

        // R5: a pending half is dropped by reset, so a register-form word is a register write.
        ctrl16(16'h4000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ctrl16(16'h8F07);
        check("R5", "step after reset cleared pending", 32'(auto_inc), 32'd7);

        // Register vector walk (R1..R4)
        for (int i = 0; i < NV; i++) begin
            reg_sel = VEC[i][39:35];
            ctrl16(VEC[i][43:28]);
            reg_sel = VEC[i][36:32];
            reg_sel = VEC[i][40:36];
            #1;
            check(VEC[i][27:24] == 4'd11 ? "R1" :
                  VEC[i][27:24] <= 4'd5  ? "R2" :
                  VEC[i][27:24] <= 4'd7  ? "R3" : "R4",
                  "register field", field(VEC[i][27:24]), 32'(VEC[i][23:0]));
        end

        // R1: undefined index 24 and 29 change nothing
        src_keep = dma_src;
        ctrl16(16'h98FF);
        ctrl16(16'h9DFF);
        reg_sel = 5'd24; #1;
        check("R1", "undefined index view", 32'(reg_val), 32'h0);
        check("R1", "source kept", 32'(dma_src), 32'(src_keep));
        check("R1", "step kept", 32'(auto_inc), 32'd2);

        // R7/R8/R9: VRAM write command, address 0x9234
        ctrl16(16'h5234);
        ctrl16(16'h0002);
        daccess(1'b0, 16'h1111, st, a, s);
        check("R9", "VRAM write strobe", 32'(st), 32'h1);
        check("R7", "assembled address", 32'(a), 32'h9234);
        check("R8", "VRAM target", 32'(s), 32'd0);
        daccess(1'b1, 16'h0, st, a, s);
        check("R9", "read strobe", 32'(st), 32'h1);
        check("R9", "address after step", 32'(a), 32'h9236);

        // R8: CRAM wraps at 128
        ctrl16(16'hC07E);
        ctrl16(16'h0000);
        daccess(1'b0, 16'h2222, st, a, s);
        check("R8", "CRAM target", 32'(s), 32'd1);
        check("R8", "CRAM address", 32'(a), 32'h7E);
        daccess(1'b0, 16'h2223, st, a, s);
        check("R8", "CRAM wrap", 32'(a), 32'h0);

        // R8: VSRAM wraps at 80
        ctrl16(16'h404E);
        ctrl16(16'h0010);
        daccess(1'b0, 16'h3333, st, a, s);
        check("R8", "VSRAM target", 32'(s), 32'd2);
        check("R8", "VSRAM address", 32'(a), 32'd78);
        daccess(1'b0, 16'h3334, st, a, s);
        check("R8", "VSRAM wrap", 32'(a), 32'h0);

        // R6: one wide write
        ctrl32(32'h4010_0000);
        daccess(1'b0, 16'h4444, st, a, s);
        check("R6", "wide write address", 32'(a), 32'h10);
        check("R6", "wide write target", 32'(s), 32'd0);

        // R5: register-form second half completes the pending command
        ctrl16(16'h4020);
        ctrl16(16'h8F04);
        check("R5", "step unchanged", 32'(auto_inc), 32'd2);
        daccess(1'b0, 16'h5555, st, a, s);
        check("R5", "completed address", 32'(a), 32'h0020);

        // R10: copy request
        ctrl16(16'h0000);
        ctrl16(16'h00C0);
        check("R10", "copy start", 32'(dma_start), 32'h1);
        check("R10", "copy kind", 32'(dma_kind), 32'd2);
        @(negedge clk);
        check("R10", "start is one cycle", 32'(dma_start), 32'h0);

        // R10: memory transfer when kind bits are not 2'b10
        ctrl16(16'h9700);
        ctrl16(16'h4000);
        ctrl16(16'h0080);
        check("R10", "memory start", 32'(dma_start), 32'h1);
        check("R10", "memory kind", 32'(dma_kind), 32'd1);

        // R11: fill armed, then started by the data write
        ctrl16(16'h9780);
        ctrl16(16'h4100);
        ctrl16(16'h0080);
        check("R11", "no start when armed", 32'(dma_start), 32'h0);
        daccess(1'b0, 16'hBEEF, st, a, s);
        check("R11", "no memory write", 32'(st), 32'h0);
        check("R11", "fill start", 32'(dma_start), 32'h1);
        check("R11", "fill kind", 32'(dma_kind), 32'd3);
        check("R11", "fill word", 32'(fill_word), 32'hBEEF);
        daccess(1'b0, 16'h6666, st, a, s);
        check("R11", "normal write after fill", 32'(st), 32'h1);
        check("R11", "address not stepped by fill", 32'(a), 32'h0100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule